// File: doc/BRIEF.md
# Interrupt Flag Collector with Qualified Read-Clear

This block keeps two event flags, one for an alarm and one for a watchdog expiry, in a flags byte. It also controls one shared open-drain pin that carries either an interrupt request or a frequency-test square wave. Each event pulse sets its flag, and the flag stays set until the host clears it. An alarm flag pulls the pin low only while the alarm enable is set. A watchdog flag pulls the pin low only while the watchdog steering input is 0. A steering value of 1 sends the watchdog to a separate reset path, which is outside this block.

The host clears both flags and releases the interrupt by reading the flags address. A read counts only after the address has stayed on the flags location, with read asserted, for `QUAL_CYCLES` consecutive clock edges. One clear is issued for each unbroken hold. Any change of address, or any drop of read, starts the count again. An event on the same edge as the clear wins, so no event is lost.

When no interrupt is pending and frequency test is on, the pin follows the square wave. A pending interrupt overrides the frequency-test use of the pin.

Top module: `intr_flag_unit`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `flags_q` is all zero and `irq_pin_oe` is 0.
- R2: An `alarm_evt` pulse sets flag bit 6 of `flags_q` and a `wdog_evt` pulse sets bit 7, both visible after the next rising clock edge. All other bits of `flags_q` read 0.
- R3: A set flag stays set on every later edge until a qualified read clears it.
- R4: A qualified read clears bits 6 and 7 at the `QUAL_CYCLES`-th consecutive edge. A qualified read is `bus_rd`=1 with `bus_addr`=`FLAG_ADDR` (default 0x1FF0, default `QUAL_CYCLES`=3).
- R5: A hold shorter than `QUAL_CYCLES` edges does not clear. Neither does a hold broken by a change of address or a drop of `bus_rd`. After a break, the count starts again from zero.
- R6: One unbroken hold clears at most once. An event that arrives while the same hold continues leaves its flag set.
- R7: An event on the same edge as the clearing edge leaves its own flag set.
- R8: With the alarm flag set, `irq_pin_oe` is 1 when `alarm_en`=1. When `alarm_en`=0, the alarm flag alone does not drive the pin.
- R9: With the watchdog flag set, `irq_pin_oe` is 1 when `wdog_steer`=0. When `wdog_steer`=1, the watchdog flag alone does not drive the pin.
- R10: With no interrupt pending, `irq_pin_oe` equals `ft_en & ~ft_wave`: the pin is pulled low during the low half of the wave, and it is released when frequency test is off.
- R11: While an interrupt is pending, `irq_pin_oe` stays 1 whatever `ft_en` and `ft_wave` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alarm_evt | input | 1 | One-cycle alarm event pulse |
| wdog_evt | input | 1 | One-cycle watchdog expiry pulse |
| alarm_en | input | 1 | Route the alarm flag onto the pin |
| wdog_steer | input | 1 | 0: watchdog flag drives the pin; 1: it does not |
| ft_en | input | 1 | Frequency-test mode enable |
| ft_wave | input | 1 | Frequency-test square wave |
| bus_addr | input | ADDR_W (13) | Host bus address |
| bus_rd | input | 1 | Host read strobe |
| flags_q | output | FLAG_W (8) | Flags byte: bit 7 watchdog, bit 6 alarm |
| irq_pin_oe | output | 1 | 1 pulls the open-drain pin low |

## Verification
The bench holds reads for exactly `QUAL_CYCLES`-1 edges, and it breaks holds by moving the address and bringing it back. A qualifier that counts too early, or that fails to restart its count, would clear the flags there. The bench also fires an event on the clearing edge itself and during a long continued hold. A design that lets the clear win would lose that event, and a design that clears again on every cycle of the hold would lose it too. The bench runs the square wave under a pending interrupt to catch a pin multiplexer that lets frequency test through. Long random stretches then mix steering, enables and partial reads, and the bench checks every cycle against its model.

// File: rtl/intr_flag_pkg.sv
package intr_flag_pkg;
   localparam int unsigned N_SRC = 2;

   typedef enum logic [0:0] {
      SRC_ALARM = 1'b0,
      SRC_WDOG  = 1'b1
   } flag_src_e;

   typedef enum logic [0:0] {
      QUAL_COUNTER = 1'b0,
      QUAL_SHIFT   = 1'b1
   } qual_impl_e;

   function automatic qual_impl_e pick_qual(input int unsigned cycles, input int unsigned shift_max);
      return (cycles <= shift_max) ? QUAL_SHIFT : QUAL_COUNTER;
   endfunction
endpackage

// File: rtl/intr_read_qual.sv
module intr_read_qual #(
   parameter int unsigned ADDR_W      = 13,
   parameter logic [ADDR_W-1:0] FLAG_ADDR = 13'h1FF0,
   parameter int unsigned QUAL_CYCLES = 3,
   parameter int unsigned SHIFT_MAX   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   output logic              clr_hit
);
   import intr_flag_pkg::*;

   localparam qual_impl_e IMPL  = pick_qual(QUAL_CYCLES, SHIFT_MAX);
   localparam int unsigned CNT_W = $clog2(QUAL_CYCLES + 1);

   logic at_flags;
   assign at_flags = bus_rd && (bus_addr == FLAG_ADDR);

   if (QUAL_CYCLES < 1) begin : g_bad_qual
      $error("QUAL_CYCLES must be at least 1");
   end

   if (IMPL == QUAL_SHIFT) begin : g_shift
      logic [QUAL_CYCLES-1:0] hist;
      logic                   run_ok;

      if (QUAL_CYCLES == 1) begin : g_one
         assign run_ok = 1'b1;
      end else begin : g_many
         assign run_ok = &hist[QUAL_CYCLES-2:0];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) hist <= '0;
         else        hist <= {hist[QUAL_CYCLES-1:0], at_flags} >> 0;
      end

      assign clr_hit = at_flags && run_ok && !hist[QUAL_CYCLES-1];
   end else begin : g_count
      logic [CNT_W-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               cnt <= '0;
         else if (!at_flags)                       cnt <= '0;
         else if (cnt != CNT_W'(QUAL_CYCLES))      cnt <= cnt + 1'b1;
      end

      assign clr_hit = at_flags && (cnt == CNT_W'(QUAL_CYCLES - 1));
   end
endmodule

// File: rtl/intr_flag_cell.sv
module intr_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_evt,
   input  logic clr,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag <= 1'b0;
      else if (set_evt) flag <= 1'b1;
      else if (clr)     flag <= 1'b0;
   end
endmodule

// File: rtl/intr_pin_mux.sv
module intr_pin_mux (
   input  logic alarm_flag,
   input  logic wdog_flag,
   input  logic alarm_en,
   input  logic wdog_steer,
   input  logic ft_en,
   input  logic ft_wave,
   output logic irq_pend,
   output logic pin_oe
);
   always_comb begin
      irq_pend = (alarm_flag && alarm_en) || (wdog_flag && !wdog_steer);
      if (irq_pend) pin_oe = 1'b1;
      else          pin_oe = ft_en && !ft_wave;
   end
endmodule

// File: rtl/intr_flag_unit.sv
module intr_flag_unit #(
   parameter int unsigned ADDR_W      = 13,
   parameter logic [ADDR_W-1:0] FLAG_ADDR = 13'h1FF0,
   parameter int unsigned QUAL_CYCLES = 3,
   parameter int unsigned SHIFT_MAX   = 8,
   parameter int unsigned FLAG_W      = 8,
   parameter int unsigned AF_BIT      = 6,
   parameter int unsigned WDF_BIT     = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alarm_evt,
   input  logic              wdog_evt,
   input  logic              alarm_en,
   input  logic              wdog_steer,
   input  logic              ft_en,
   input  logic              ft_wave,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   output logic [FLAG_W-1:0] flags_q,
   output logic              irq_pin_oe
);
   import intr_flag_pkg::*;

   if (AF_BIT >= FLAG_W || WDF_BIT >= FLAG_W || AF_BIT == WDF_BIT) begin : g_bad_bits
      $error("flag bit positions must be distinct and inside FLAG_W");
   end

   logic             clr_hit;
   logic             irq_pend;
   logic [N_SRC-1:0] src_evt;
   logic [N_SRC-1:0] src_flag;

   assign src_evt[SRC_ALARM] = alarm_evt;
   assign src_evt[SRC_WDOG]  = wdog_evt;

   intr_read_qual #(
      .ADDR_W      (ADDR_W),
      .FLAG_ADDR   (FLAG_ADDR),
      .QUAL_CYCLES (QUAL_CYCLES),
      .SHIFT_MAX   (SHIFT_MAX)
   ) u_qual (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (bus_addr),
      .bus_rd   (bus_rd),
      .clr_hit  (clr_hit)
   );

   for (genvar i = 0; i < N_SRC; i++) begin : g_cell
      intr_flag_cell u_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .set_evt (src_evt[i]),
         .clr     (clr_hit),
         .flag    (src_flag[i])
      );
   end

   always_comb begin
      flags_q          = '0;
      flags_q[AF_BIT]  = src_flag[SRC_ALARM];
      flags_q[WDF_BIT] = src_flag[SRC_WDOG];
   end

   intr_pin_mux u_mux (
      .alarm_flag (src_flag[SRC_ALARM]),
      .wdog_flag  (src_flag[SRC_WDOG]),
      .alarm_en   (alarm_en),
      .wdog_steer (wdog_steer),
      .ft_en      (ft_en),
      .ft_wave    (ft_wave),
      .irq_pend   (irq_pend),
      .pin_oe     (irq_pin_oe)
   );
endmodule

// File: rtl/intr_flag_unit_chk.sv
module intr_flag_unit_chk #(
   parameter int unsigned FLAG_W  = 8,
   parameter int unsigned AF_BIT  = 6,
   parameter int unsigned WDF_BIT = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              alarm_evt,
   input logic              wdog_evt,
   input logic              alarm_en,
   input logic              wdog_steer,
   input logic              ft_en,
   input logic              ft_wave,
   input logic              clr_hit,
   input logic [FLAG_W-1:0] flags_q,
   input logic              irq_pin_oe
);
   // R2
   alarm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_evt |=> flags_q[AF_BIT]);

   // R2
   wdog_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wdog_evt |=> flags_q[WDF_BIT]);

   // R4
   read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit && !alarm_evt && !wdog_evt) |=> (!flags_q[AF_BIT] && !flags_q[WDF_BIT]));

   // R5
   no_early_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flags_q[AF_BIT]) |-> $past(clr_hit));

   // R7
   evt_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit && alarm_evt) |=> flags_q[AF_BIT]);

   // R8
   alarm_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_q[AF_BIT] && alarm_en) |-> irq_pin_oe);

   // R9
   wdog_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_q[WDF_BIT] && !wdog_steer) |-> irq_pin_oe);

   // R10
   pin_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ft_en && !(flags_q[AF_BIT] && alarm_en) && !(flags_q[WDF_BIT] && !wdog_steer)) |-> !irq_pin_oe);

   // R11
   ft_suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ft_en && ft_wave && flags_q[WDF_BIT] && !wdog_steer) |-> irq_pin_oe);
endmodule

bind intr_flag_unit intr_flag_unit_chk #(
   .FLAG_W  (FLAG_W),
   .AF_BIT  (AF_BIT),
   .WDF_BIT (WDF_BIT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .alarm_evt  (alarm_evt),
   .wdog_evt   (wdog_evt),
   .alarm_en   (alarm_en),
   .wdog_steer (wdog_steer),
   .ft_en      (ft_en),
   .ft_wave    (ft_wave),
   .clr_hit    (clr_hit),
   .flags_q    (flags_q),
   .irq_pin_oe (irq_pin_oe)
);

// File: tb/intr_flag_unit_test.sv
`timescale 1ns/1ps
module intr_flag_unit_test;
   localparam int unsigned ADDR_W = 13;
   localparam logic [ADDR_W-1:0] FLAG_ADDR = 13'h1FF0;
   localparam int unsigned QUAL = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              alarm_evt = 1'b0, wdog_evt = 1'b0;
   logic              alarm_en = 1'b0, wdog_steer = 1'b1;
   logic              ft_en = 1'b0, ft_wave = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic              bus_rd = 1'b0;
   logic [7:0]        flags_q;
   logic              irq_pin_oe;

   int unsigned n_tests = 0, n_fail = 0, cycles = 0;
   string       cur_tag = "R1";

   // bench model state
   logic m_af = 1'b0, m_wdf = 1'b0;
   int unsigned m_cnt = 0;

   always #2.5 clk = ~clk;

   intr_flag_unit uut (
      .clk(clk), .rst_n(rst_n), .alarm_evt(alarm_evt), .wdog_evt(wdog_evt),
      .alarm_en(alarm_en), .wdog_steer(wdog_steer), .ft_en(ft_en), .ft_wave(ft_wave),
      .bus_addr(bus_addr), .bus_rd(bus_rd), .flags_q(flags_q), .irq_pin_oe(irq_pin_oe)
   );

   function automatic logic m_hold(logic rd, logic [ADDR_W-1:0] a);
      return rd && (a == FLAG_ADDR);
   endfunction

   function automatic logic m_pin(logic af, logic wdf, logic aen, logic st, logic fe, logic fw);
      logic pend;
      pend = (af && aen) || (wdf && !st);
      return pend ? 1'b1 : (fe && !fw);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_af <= 1'b0; m_wdf <= 1'b0; m_cnt <= 0;
      end else begin
         logic hold, clr;
         hold = m_hold(bus_rd, bus_addr);
         clr  = hold && (m_cnt == QUAL - 1);
         m_af  <= alarm_evt || (m_af && !clr);
         m_wdf <= wdog_evt || (m_wdf && !clr);
         m_cnt <= !hold ? 0 : ((m_cnt < QUAL) ? m_cnt + 1 : m_cnt);
      end
   end

   task automatic check(string tag, logic [7:0] got, logic [7:0] exp, string what);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
      end
   endtask

   // wait for the next falling edge and compare outputs with the model
   task automatic tick();
      logic [7:0] ef;
      @(negedge clk);
      ef = 8'h00; ef[6] = m_af; ef[7] = m_wdf;
      check(cur_tag, flags_q, ef, "flags");
      check(cur_tag, {7'd0, irq_pin_oe},
            {7'd0, m_pin(m_af, m_wdf, alarm_en, wdog_steer, ft_en, ft_wave)}, "pin_oe");
   endtask

   task automatic clear_inputs();
      alarm_evt = 1'b0; wdog_evt = 1'b0;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_fail++;
         $display("FAIL watchdog: got hang expected finish");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      cur_tag = "R1";
      repeat (3) @(negedge clk);
      check("R1", flags_q, 8'h00, "flags in reset");
      check("R1", {7'd0, irq_pin_oe}, 8'h00, "pin in reset");
      rst_n = 1'b1;
      tick();

      // R2 alarm sets bit 6, not routed (R8 off)
      cur_tag = "R2"; alarm_evt = 1'b1; tick(); clear_inputs();
      check("R2", flags_q, 8'h40, "alarm flag");
      cur_tag = "R8"; check("R8", {7'd0, irq_pin_oe}, 8'h00, "alarm disabled pin");
      // R3 persistence
      cur_tag = "R3"; repeat (4) tick();
      // R8 enable routes alarm
      cur_tag = "R8"; alarm_en = 1'b1; tick();
      check("R8", {7'd0, irq_pin_oe}, 8'h01, "alarm enabled pin");

      // R5 short hold
      cur_tag = "R5"; bus_addr = FLAG_ADDR; bus_rd = 1'b1;
      repeat (QUAL - 1) tick();
      bus_rd = 1'b0; tick();
      check("R5", flags_q, 8'h40, "short hold keeps flag");
      // R5 broken by address change
      bus_rd = 1'b1; repeat (QUAL - 1) tick();
      bus_addr = FLAG_ADDR + 1; tick();
      bus_addr = FLAG_ADDR; repeat (QUAL - 1) tick();
      check("R5", flags_q, 8'h40, "restarted hold keeps flag");
      // R4 completes
      cur_tag = "R4"; tick();
      check("R4", flags_q, 8'h00, "qualified read clears");
      // R6 watchdog during continued hold, R9 routed
      cur_tag = "R6"; wdog_steer = 1'b0; wdog_evt = 1'b1; tick(); clear_inputs();
      repeat (QUAL + 2) tick();
      check("R6", flags_q, 8'h80, "no second clear in one hold");
      cur_tag = "R9"; check("R9", {7'd0, irq_pin_oe}, 8'h01, "watchdog routed pin");
      wdog_steer = 1'b1; tick();
      check("R9", {7'd0, irq_pin_oe}, 8'h00, "watchdog steered away");
      wdog_steer = 1'b0;
      bus_rd = 1'b0; tick();

      // R7 alarm on the clearing edge
      cur_tag = "R7"; bus_rd = 1'b1;
      repeat (QUAL - 1) tick();
      alarm_evt = 1'b1; tick(); clear_inputs();
      check("R7", flags_q, 8'h40, "event on clear edge survives");
      bus_rd = 1'b0; tick();

      // R11 pending interrupt beats frequency test
      cur_tag = "R11"; ft_en = 1'b1;
      for (int k = 0; k < 6; k++) begin ft_wave = k[0]; tick(); end
      check("R11", {7'd0, irq_pin_oe}, 8'h01, "ft suppressed");
      // clear, then R10 wave on pin
      bus_rd = 1'b1; repeat (QUAL) tick(); bus_rd = 1'b0;
      cur_tag = "R10";
      for (int k = 0; k < 6; k++) begin ft_wave = k[0]; tick(); end
      ft_wave = 1'b0; tick();
      check("R10", {7'd0, irq_pin_oe}, 8'h01, "wave low pulls pin");
      ft_en = 1'b0; tick();
      check("R10", {7'd0, irq_pin_oe}, 8'h00, "ft off releases pin");

      // constrained random mix, every cycle checked against the model (R4)
      cur_tag = "R4";
      void'($urandom(32'h5eed_1234));
      for (int n = 0; n < 4000; n++) begin
         alarm_evt = ($urandom % 100) < 4;
         wdog_evt  = ($urandom % 100) < 3;
         if (($urandom % 100) < 3) alarm_en   = ~alarm_en;
         if (($urandom % 100) < 3) wdog_steer = ~wdog_steer;
         if (($urandom % 100) < 2) ft_en      = ~ft_en;
         if (($urandom % 4) == 0)  ft_wave    = ~ft_wave;
         if (($urandom % 100) < 20) bus_rd    = ~bus_rd;
         if (($urandom % 100) < 10)
            bus_addr = (($urandom % 2) == 0) ? FLAG_ADDR : ADDR_W'($urandom);
         tick();
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule